// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block moves a processor from ordinary execution into an exception or interrupt handler in a single committed step. The pipeline presents a pending exception code, an interrupt request, the current status word, program counter, vector base, stack register and the delay-slot and sleep flags, and pulses `take_i`. On the next clock edge the block commits all of the entry state at once. That state is the saved status, the saved PC, the saved stack register, the event code register, the updated status word and the handler address. It can also commit a reset request instead.

An exception outranks an interrupt. When the status word's block bit is set, a pending exception other than the exempt code becomes a reset request. Interrupts are held off unless the core is asleep. The interrupt controller gets the current mask level from the block and answers with a vector code or with no vector. Handler addresses are a fixed reset address for reset-class codes, or one of three offsets from the vector base. The saved PC is wound back one instruction for a delay slot and moved forward one instruction for the trap code.

Top module: `exc_entry_seq`

## Requirements
- R1: When `exc_valid_i` and `irq_req_i` are both high, the exception is taken: `expevt_o` receives the code, the handler is chosen from the exception code, and `intevt_o` keeps its value.
- R2: With SR bit 28 (block) set and an exception pending whose code is not 0x1E0, the edge after `take_i` pulses `rst_req_o` for one cycle. `entry_o` stays low and every saved-state, event, SR and PC output holds. Code 0x1E0 is entered normally.
- R3: With SR bit 28 set, no exception pending and an interrupt requested, nothing is entered while `sleep_i` is low. The interrupt is entered while `sleep_i` is high.
- R4: `imask_o` always equals SR bits 7:4. An interrupt request with `irq_vec_valid_i` low causes no entry and no output change.
- R5: On entry, `ssr_o` takes SR, `sgr_o` takes R15, and `sr_o` is SR with bits 28, 29 and 30 set. `sleep_clr_o` pulses when `sleep_i` was high.
- R6: On entry with `dslot_i` high, `spc_o` is PC minus 2 and `dslot_clr_o` pulses. Otherwise `spc_o` is PC.
- R7: Codes 0x000, 0x020 and 0x140 jump to 0xA0000000. In `sr_o`, bit 15 is cleared and bits 7:4 are set to 0xF.
- R8: Codes 0x040 and 0x060 jump to VBR+0x400. All other non-reset-class codes jump to VBR+0x100. Code 0x160 also adds 2 to the saved PC, on top of any delay-slot rewind.
- R9: An interrupt entry writes the vector into `intevt_o` and jumps to VBR+0x600, with `expevt_o` unchanged. An exception entry writes the code into `expevt_o`.
- R10: An interrupt request with `dslot_i` high and no exception pending is refused, and no output changes.
- R11: Outputs update only on the edge after `take_i`. `done_o` is high for exactly the cycle after each `take_i`. Reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| take_i | input | 1 | Evaluate the pending event this cycle |
| exc_valid_i | input | 1 | An exception code is pending |
| exc_code_i | input | CODE_W | Pending exception code |
| irq_req_i | input | 1 | An interrupt is requested |
| irq_vec_valid_i | input | 1 | Controller supplies a vector for the current mask |
| irq_vec_i | input | CODE_W | Interrupt vector code |
| imask_o | output | IMASK_W | Current interrupt mask level sent to the controller |
| sr_i | input | XLEN | Current status word |
| pc_i | input | XLEN | Current program counter |
| vbr_i | input | XLEN | Vector base |
| r15_i | input | XLEN | Current stack register |
| dslot_i | input | 1 | Current instruction sits in a branch delay slot |
| sleep_i | input | 1 | Core is sleeping |
| ssr_o | output | XLEN | Saved status word |
| spc_o | output | XLEN | Saved program counter |
| sgr_o | output | XLEN | Saved stack register |
| expevt_o | output | CODE_W | Last exception event code |
| intevt_o | output | CODE_W | Last interrupt event code |
| sr_o | output | XLEN | Status word for the handler |
| pc_o | output | XLEN | Handler address |
| dslot_clr_o | output | 1 | Pulse: clear the delay-slot flag |
| sleep_clr_o | output | 1 | Pulse: clear the sleep flag |
| rst_req_o | output | 1 | Pulse: request a reset |
| entry_o | output | 1 | Pulse: an entry was committed |
| done_o | output | 1 | Pulse: the take request was processed |

## Verification
The bench builds the block with its default parameters: a 32-bit word, 12-bit event codes, and the block, mode, bank and FPU-disable bits at positions 28, 30, 29 and 15. This places the base, stack and PC values at realistic high addresses, where the vector offsets add without carry surprises. It also makes every code class reachable: reset-class, TLB-miss, trap, general, and the exempt code under the block bit. The bench also covers combinations of delay slot with trap and with reset-class codes, and the sleep and missing-vector paths for interrupts.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_EXC   = 2'd1,
        ACT_IRQ   = 2'd2,
        ACT_RESET = 2'd3
    } entry_act_e;

    localparam int unsigned EVT_W = 12;

    localparam logic [EVT_W-1:0] EVT_POWERON  = 12'h000;
    localparam logic [EVT_W-1:0] EVT_MANUAL   = 12'h020;
    localparam logic [EVT_W-1:0] EVT_MULTIHIT = 12'h140;
    localparam logic [EVT_W-1:0] EVT_MISS_RD  = 12'h040;
    localparam logic [EVT_W-1:0] EVT_MISS_WR  = 12'h060;
    localparam logic [EVT_W-1:0] EVT_TRAP     = 12'h160;
    localparam logic [EVT_W-1:0] EVT_EXEMPT   = 12'h1E0;

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_entry_pkg::*;
#(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned CODE_W = 12,
    parameter int unsigned BL_BIT = 28
) (
    input  logic              exc_valid,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              irq_req,
    input  logic              vec_valid,
    input  logic [XLEN-1:0]   sr,
    input  logic              dslot,
    input  logic              sleep,
    output entry_act_e        act
);

    logic blocked;
    logic exempt;
    logic irq_ok;

    always_comb begin
        blocked = sr[BL_BIT];
        exempt  = (exc_code == CODE_W'(EVT_EXEMPT));
        irq_ok  = irq_req && !dslot && (!blocked || sleep) && vec_valid;
        act     = ACT_NONE;
        if (exc_valid) begin
            act = (blocked && !exempt) ? ACT_RESET : ACT_EXC;
        end else if (irq_ok) begin
            act = ACT_IRQ;
        end
    end

endmodule

// File: rtl/exc_target.sv
module exc_target
    import exc_entry_pkg::*;
#(
    parameter int unsigned XLEN       = 32,
    parameter int unsigned CODE_W     = 12,
    parameter int unsigned BL_BIT     = 28,
    parameter int unsigned MD_BIT     = 30,
    parameter int unsigned RB_BIT     = 29,
    parameter int unsigned FD_BIT     = 15,
    parameter int unsigned IMASK_LSB  = 4,
    parameter int unsigned IMASK_W    = 4,
    parameter logic [XLEN-1:0] RESET_PC = 32'hA000_0000,
    parameter logic [XLEN-1:0] OFS_GEN  = 32'h0000_0100,
    parameter logic [XLEN-1:0] OFS_TLB  = 32'h0000_0400,
    parameter logic [XLEN-1:0] OFS_IRQ  = 32'h0000_0600,
    parameter int unsigned INSN_BYTES = 2
) (
    input  entry_act_e        act,
    input  logic [CODE_W-1:0] code,
    input  logic [XLEN-1:0]   sr,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   vbr,
    input  logic              dslot,
    output logic [XLEN-1:0]   save_pc,
    output logic [XLEN-1:0]   new_sr,
    output logic [XLEN-1:0]   new_pc
);

    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    logic reset_class;
    logic tlb_class;
    logic [XLEN-1:0] back;
    logic [XLEN-1:0] fwd;

    always_comb begin
        reset_class = (code == CODE_W'(EVT_POWERON)) || (code == CODE_W'(EVT_MANUAL))
                   || (code == CODE_W'(EVT_MULTIHIT));
        tlb_class   = (code == CODE_W'(EVT_MISS_RD)) || (code == CODE_W'(EVT_MISS_WR));

        back    = dslot ? STEP : '0;
        fwd     = (act == ACT_EXC && code == CODE_W'(EVT_TRAP)) ? STEP : '0;
        save_pc = pc - back + fwd;

        new_sr         = sr;
        new_sr[BL_BIT] = 1'b1;
        new_sr[MD_BIT] = 1'b1;
        new_sr[RB_BIT] = 1'b1;
        new_pc         = vbr + OFS_GEN;

        if (act == ACT_IRQ) begin
            new_pc = vbr + OFS_IRQ;
        end else if (reset_class) begin
            new_sr[FD_BIT]                   = 1'b0;
            new_sr[IMASK_LSB +: IMASK_W]     = '1;
            new_pc                           = RESET_PC;
        end else if (tlb_class) begin
            new_pc = vbr + OFS_TLB;
        end
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int unsigned XLEN       = 32,
    parameter int unsigned CODE_W     = 12,
    parameter int unsigned BL_BIT     = 28,
    parameter int unsigned MD_BIT     = 30,
    parameter int unsigned RB_BIT     = 29,
    parameter int unsigned FD_BIT     = 15,
    parameter int unsigned IMASK_LSB  = 4,
    parameter int unsigned IMASK_W    = 4,
    parameter logic [XLEN-1:0] RESET_PC = 32'hA000_0000,
    parameter logic [XLEN-1:0] OFS_GEN  = 32'h0000_0100,
    parameter logic [XLEN-1:0] OFS_TLB  = 32'h0000_0400,
    parameter logic [XLEN-1:0] OFS_IRQ  = 32'h0000_0600,
    parameter int unsigned INSN_BYTES = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               take_i,
    input  logic               exc_valid_i,
    input  logic [CODE_W-1:0]  exc_code_i,
    input  logic               irq_req_i,
    input  logic               irq_vec_valid_i,
    input  logic [CODE_W-1:0]  irq_vec_i,
    output logic [IMASK_W-1:0] imask_o,
    input  logic [XLEN-1:0]    sr_i,
    input  logic [XLEN-1:0]    pc_i,
    input  logic [XLEN-1:0]    vbr_i,
    input  logic [XLEN-1:0]    r15_i,
    input  logic               dslot_i,
    input  logic               sleep_i,
    output logic [XLEN-1:0]    ssr_o,
    output logic [XLEN-1:0]    spc_o,
    output logic [XLEN-1:0]    sgr_o,
    output logic [CODE_W-1:0]  expevt_o,
    output logic [CODE_W-1:0]  intevt_o,
    output logic [XLEN-1:0]    sr_o,
    output logic [XLEN-1:0]    pc_o,
    output logic               dslot_clr_o,
    output logic               sleep_clr_o,
    output logic               rst_req_o,
    output logic               entry_o,
    output logic               done_o
);

    typedef struct packed {
        logic [XLEN-1:0]   ssr;
        logic [XLEN-1:0]   spc;
        logic [XLEN-1:0]   sgr;
        logic [CODE_W-1:0] expevt;
        logic [CODE_W-1:0] intevt;
        logic [XLEN-1:0]   sr;
        logic [XLEN-1:0]   pc;
        logic              dslot_clr;
        logic              sleep_clr;
        logic              rst_req;
        logic              entry;
        logic              done;
    } entry_state_t;

    entry_state_t st_d, st_q;
    entry_act_e   act;
    logic [XLEN-1:0] save_pc;
    logic [XLEN-1:0] new_sr;
    logic [XLEN-1:0] new_pc;

    assign imask_o = sr_i[IMASK_LSB +: IMASK_W];

    exc_arbiter #(
        .XLEN   (XLEN),
        .CODE_W (CODE_W),
        .BL_BIT (BL_BIT)
    ) u_arb (
        .exc_valid (exc_valid_i),
        .exc_code  (exc_code_i),
        .irq_req   (irq_req_i),
        .vec_valid (irq_vec_valid_i),
        .sr        (sr_i),
        .dslot     (dslot_i),
        .sleep     (sleep_i),
        .act       (act)
    );

    exc_target #(
        .XLEN       (XLEN),
        .CODE_W     (CODE_W),
        .BL_BIT     (BL_BIT),
        .MD_BIT     (MD_BIT),
        .RB_BIT     (RB_BIT),
        .FD_BIT     (FD_BIT),
        .IMASK_LSB  (IMASK_LSB),
        .IMASK_W    (IMASK_W),
        .RESET_PC   (RESET_PC),
        .OFS_GEN    (OFS_GEN),
        .OFS_TLB    (OFS_TLB),
        .OFS_IRQ    (OFS_IRQ),
        .INSN_BYTES (INSN_BYTES)
    ) u_tgt (
        .act     (act),
        .code    (exc_code_i),
        .sr      (sr_i),
        .pc      (pc_i),
        .vbr     (vbr_i),
        .dslot   (dslot_i),
        .save_pc (save_pc),
        .new_sr  (new_sr),
        .new_pc  (new_pc)
    );

    always_comb begin
        st_d           = st_q;
        st_d.done      = take_i;
        st_d.entry     = 1'b0;
        st_d.rst_req   = 1'b0;
        st_d.dslot_clr = 1'b0;
        st_d.sleep_clr = 1'b0;
        if (take_i) begin
            unique case (act)
                ACT_RESET: st_d.rst_req = 1'b1;
                ACT_EXC, ACT_IRQ: begin
                    st_d.entry     = 1'b1;
                    st_d.ssr       = sr_i;
                    st_d.spc       = save_pc;
                    st_d.sgr       = r15_i;
                    st_d.sr        = new_sr;
                    st_d.pc        = new_pc;
                    st_d.dslot_clr = dslot_i;
                    st_d.sleep_clr = sleep_i;
                    if (act == ACT_EXC) begin
                        st_d.expevt = exc_code_i;
                    end else begin
                        st_d.intevt = irq_vec_i;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ssr_o       = st_q.ssr;
    assign spc_o       = st_q.spc;
    assign sgr_o       = st_q.sgr;
    assign expevt_o    = st_q.expevt;
    assign intevt_o    = st_q.intevt;
    assign sr_o        = st_q.sr;
    assign pc_o        = st_q.pc;
    assign dslot_clr_o = st_q.dslot_clr;
    assign sleep_clr_o = st_q.sleep_clr;
    assign rst_req_o   = st_q.rst_req;
    assign entry_o     = st_q.entry;
    assign done_o      = st_q.done;

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
#(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned CODE_W = 12,
    parameter int unsigned BL_BIT = 28
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              take_i,
    input logic              exc_valid_i,
    input logic [CODE_W-1:0] exc_code_i,
    input logic              sleep_i,
    input logic              dslot_i,
    input logic [XLEN-1:0]   sr_i,
    input logic [XLEN-1:0]   r15_i,
    input logic [XLEN-1:0]   ssr_o,
    input logic [XLEN-1:0]   sgr_o,
    input logic [XLEN-1:0]   pc_o,
    input logic [CODE_W-1:0] expevt_o,
    input logic [CODE_W-1:0] intevt_o,
    input logic              rst_req_o,
    input logic              entry_o,
    input logic              done_o
);

    a_r11_done_after_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_i |=> done_o);

    a_r11_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !take_i |=> (!done_o && !entry_o && $stable(pc_o)));

    a_r2_blocked_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_i && exc_valid_i && sr_i[BL_BIT] && exc_code_i != CODE_W'(EVT_EXEMPT))
        |=> (rst_req_o && !entry_o && $stable(pc_o) && $stable(ssr_o)));

    a_r1_exc_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_i && exc_valid_i && !sr_i[BL_BIT])
        |=> (entry_o && expevt_o == $past(exc_code_i) && $stable(intevt_o)));

    a_r5_saved_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_i && exc_valid_i && !sr_i[BL_BIT])
        |=> (ssr_o == $past(sr_i) && sgr_o == $past(r15_i)));

    a_r10_dslot_refuse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_i && !exc_valid_i && dslot_i) |=> (!entry_o && $stable(pc_o)));

    a_r3_blocked_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_i && !exc_valid_i && sr_i[BL_BIT] && !sleep_i) |=> !entry_o);

    a_r2_pulse_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({entry_o, rst_req_o}));

endmodule

bind exc_entry_seq exc_entry_chk #(
    .XLEN   (XLEN),
    .CODE_W (CODE_W),
    .BL_BIT (BL_BIT)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_i      (take_i),
    .exc_valid_i (exc_valid_i),
    .exc_code_i  (exc_code_i),
    .sleep_i     (sleep_i),
    .dslot_i     (dslot_i),
    .sr_i        (sr_i),
    .r15_i       (r15_i),
    .ssr_o       (ssr_o),
    .sgr_o       (sgr_o),
    .pc_o        (pc_o),
    .expevt_o    (expevt_o),
    .intevt_o    (intevt_o),
    .rst_req_o   (rst_req_o),
    .entry_o     (entry_o),
    .done_o      (done_o)
);

// File: tb/tb_exc_entry_seq.sv
`timescale 1ns/1ps
module tb_exc_entry_seq;

    localparam logic [31:0] VBR = 32'h8C00_0000;
    localparam logic [31:0] PC  = 32'h8C00_1000;
    localparam logic [31:0] R15 = 32'h1234_5678;
    localparam logic [31:0] S0  = 32'h0000_8050;
    localparam logic [31:0] SB  = 32'h1000_8050;
    localparam logic [31:0] SE  = 32'h7000_8050;
    localparam logic [31:0] SR7 = 32'h7000_00F0;

    typedef struct packed {
        logic        ev;
        logic [11:0] code;
        logic        irq;
        logic        vv;
        logic [11:0] vec;
        logic [31:0] sr;
        logic        ds;
        logic        sl;
        logic [1:0]  kind;   // 0 none, 1 exception, 2 interrupt, 3 reset request
        logic [31:0] pc;
        logic [31:0] spc;
        logic [31:0] sro;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 12'h180, 1'b0, 1'b0, 12'h000, S0, 1'b0, 1'b0, 2'd1, 32'h8C00_0100, PC, SE},            // R8 general
        '{1'b1, 12'h040, 1'b0, 1'b0, 12'h000, S0, 1'b0, 1'b0, 2'd1, 32'h8C00_0400, PC, SE},            // R8 miss read
        '{1'b1, 12'h060, 1'b0, 1'b0, 12'h000, S0, 1'b0, 1'b0, 2'd1, 32'h8C00_0400, PC, SE},            // R8 miss write
        '{1'b1, 12'h140, 1'b0, 1'b0, 12'h000, S0, 1'b0, 1'b0, 2'd1, 32'hA000_0000, PC, SR7},           // R7
        '{1'b1, 12'h000, 1'b0, 1'b0, 12'h000, S0, 1'b0, 1'b0, 2'd1, 32'hA000_0000, PC, SR7},           // R7
        '{1'b1, 12'h020, 1'b0, 1'b0, 12'h000, S0, 1'b0, 1'b0, 2'd1, 32'hA000_0000, PC, SR7},           // R7
        '{1'b1, 12'h160, 1'b0, 1'b0, 12'h000, S0, 1'b0, 1'b0, 2'd1, 32'h8C00_0100, 32'h8C00_1002, SE}, // R8 trap
        '{1'b1, 12'h180, 1'b0, 1'b0, 12'h000, S0, 1'b1, 1'b0, 2'd1, 32'h8C00_0100, 32'h8C00_0FFE, SE}, // R6
        '{1'b1, 12'h160, 1'b0, 1'b0, 12'h000, S0, 1'b1, 1'b0, 2'd1, 32'h8C00_0100, PC, SE},            // R6 + R8
        '{1'b0, 12'h000, 1'b1, 1'b1, 12'h320, S0, 1'b0, 1'b0, 2'd2, 32'h8C00_0600, PC, SE},            // R9
        '{1'b1, 12'h0E0, 1'b1, 1'b1, 12'h3A0, S0, 1'b0, 1'b0, 2'd1, 32'h8C00_0100, PC, SE},            // R1
        '{1'b1, 12'h0A0, 1'b0, 1'b0, 12'h000, SB, 1'b0, 1'b0, 2'd3, 32'h0, 32'h0, 32'h0},              // R2
        '{1'b1, 12'h1E0, 1'b0, 1'b0, 12'h000, SB, 1'b0, 1'b0, 2'd1, 32'h8C00_0100, PC, SE},            // R2 exempt
        '{1'b0, 12'h000, 1'b1, 1'b1, 12'h2A0, SB, 1'b0, 1'b0, 2'd0, 32'h0, 32'h0, 32'h0},              // R3 held
        '{1'b0, 12'h000, 1'b1, 1'b1, 12'h200, SB, 1'b0, 1'b1, 2'd2, 32'h8C00_0600, PC, SE},            // R3 asleep
        '{1'b0, 12'h000, 1'b1, 1'b0, 12'h000, S0, 1'b0, 1'b0, 2'd0, 32'h0, 32'h0, 32'h0},              // R4 no vector
        '{1'b0, 12'h000, 1'b1, 1'b1, 12'h300, S0, 1'b1, 1'b0, 2'd0, 32'h0, 32'h0, 32'h0},              // R10
        '{1'b1, 12'h140, 1'b0, 1'b0, 12'h000, S0, 1'b1, 1'b0, 2'd1, 32'hA000_0000, 32'h8C00_0FFE, SR7} // R7 + R6
    };

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        take_i = 1'b0;
    logic        exc_valid_i = 1'b0;
    logic [11:0] exc_code_i = '0;
    logic        irq_req_i = 1'b0;
    logic        irq_vec_valid_i = 1'b0;
    logic [11:0] irq_vec_i = '0;
    logic [3:0]  imask_o;
    logic [31:0] sr_i = '0;
    logic [31:0] pc_i = PC;
    logic [31:0] vbr_i = VBR;
    logic [31:0] r15_i = R15;
    logic        dslot_i = 1'b0;
    logic        sleep_i = 1'b0;
    logic [31:0] ssr_o, spc_o, sgr_o, sr_o, pc_o;
    logic [11:0] expevt_o, intevt_o;
    logic        dslot_clr_o, sleep_clr_o, rst_req_o, entry_o, done_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk_i = ~clk_i;

    exc_entry_seq dut (
        .clk_i(clk_i), .rst_ni(rst_ni), .take_i(take_i),
        .exc_valid_i(exc_valid_i), .exc_code_i(exc_code_i),
        .irq_req_i(irq_req_i), .irq_vec_valid_i(irq_vec_valid_i), .irq_vec_i(irq_vec_i),
        .imask_o(imask_o), .sr_i(sr_i), .pc_i(pc_i), .vbr_i(vbr_i), .r15_i(r15_i),
        .dslot_i(dslot_i), .sleep_i(sleep_i),
        .ssr_o(ssr_o), .spc_o(spc_o), .sgr_o(sgr_o), .expevt_o(expevt_o), .intevt_o(intevt_o),
        .sr_o(sr_o), .pc_o(pc_o), .dslot_clr_o(dslot_clr_o), .sleep_clr_o(sleep_clr_o),
        .rst_req_o(rst_req_o), .entry_o(entry_o), .done_o(done_o)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    logic [31:0] m_ssr, m_spc, m_sgr, m_sr, m_pc;
    logic [11:0] m_exp, m_int;

    task automatic check_all(input string rq);
        chk({rq, " ssr"}, ssr_o, m_ssr);
        chk({rq, " spc"}, spc_o, m_spc);
        chk({rq, " sgr"}, sgr_o, m_sgr);
        chk({rq, " sr"}, sr_o, m_sr);
        chk({rq, " pc"}, pc_o, m_pc);
        chk({rq, " expevt"}, 32'(expevt_o), 32'(m_exp));
        chk({rq, " intevt"}, 32'(intevt_o), 32'(m_int));
    endtask

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_ssr = '0; m_spc = '0; m_sgr = '0; m_sr = '0; m_pc = '0; m_exp = '0; m_int = '0;
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        // R11 reset state
        check_all("R11 reset");
        chk("R11 reset done", 32'(done_o), 32'd0);
        chk("R11 reset entry", 32'(entry_o), 32'd0);
        rst_ni = 1'b1;
        @(negedge clk_i);

        for (int i = 0; i < NV; i++) begin
            exc_valid_i     = TBL[i].ev;
            exc_code_i      = TBL[i].code;
            irq_req_i       = TBL[i].irq;
            irq_vec_valid_i = TBL[i].vv;
            irq_vec_i       = TBL[i].vec;
            sr_i            = TBL[i].sr;
            dslot_i         = TBL[i].ds;
            sleep_i         = TBL[i].sl;
            take_i          = 1'b1;
            #1;
            chk("R4 imask", 32'(imask_o), 32'(TBL[i].sr[7:4]));
            @(negedge clk_i);
            take_i = 1'b0;
            if (TBL[i].kind == 2'd1 || TBL[i].kind == 2'd2) begin
                m_ssr = TBL[i].sr; m_sgr = R15; m_spc = TBL[i].spc;
                m_sr  = TBL[i].sro; m_pc = TBL[i].pc;
                if (TBL[i].kind == 2'd1) m_exp = TBL[i].code;
                else                      m_int = TBL[i].vec;
            end
            // R5 R6 R7 R8 R9 register values; R2 R3 R4 R10 unchanged when no entry
            check_all($sformatf("R5/R8 vec%0d", i));
            chk("R2 reset request", 32'(rst_req_o), 32'(TBL[i].kind == 2'd3));
            chk("R3 entry", 32'(entry_o), 32'(TBL[i].kind == 2'd1 || TBL[i].kind == 2'd2));
            chk("R6 dslot clear", 32'(dslot_clr_o),
                32'((TBL[i].kind == 2'd1 || TBL[i].kind == 2'd2) && TBL[i].ds));
            chk("R5 sleep clear", 32'(sleep_clr_o),
                32'((TBL[i].kind == 2'd1 || TBL[i].kind == 2'd2) && TBL[i].sl));
            chk("R11 done", 32'(done_o), 32'd1);
            @(negedge clk_i);
            chk("R11 done drops", 32'(done_o), 32'd0);
            chk("R2 pulse drops", 32'(rst_req_o | entry_o), 32'd0);
        end

        // R11: inputs that would enter change nothing without take
        exc_valid_i = 1'b1; exc_code_i = 12'h180; sr_i = S0; dslot_i = 1'b0; sleep_i = 1'b0;
        irq_req_i = 1'b0; pc_i = 32'h8C00_2000;
        repeat (2) @(negedge clk_i);
        check_all("R11 no take");
        chk("R11 no take entry", 32'(entry_o), 32'd0);

        // R9: exception entry leaves intevt; then interrupt leaves expevt
        take_i = 1'b1;
        @(negedge clk_i);
        take_i = 1'b0;
        chk("R9 expevt set", 32'(expevt_o), 32'h180);
        chk("R9 intevt kept", 32'(intevt_o), 32'(m_int));
        chk("R11 new pc source", spc_o, 32'h8C00_2000);
        exc_valid_i = 1'b0; irq_req_i = 1'b1; irq_vec_valid_i = 1'b1; irq_vec_i = 12'h5C0;
        take_i = 1'b1;
        @(negedge clk_i);
        take_i = 1'b0;
        chk("R9 intevt set", 32'(intevt_o), 32'h5C0);
        chk("R9 expevt kept", 32'(expevt_o), 32'h180);
        chk("R9 irq pc", pc_o, 32'h8C00_0600);

        // R10: delay-slot interrupt refused, yet an exception in a delay slot enters (R1)
        dslot_i = 1'b1; irq_vec_i = 12'h640;
        take_i = 1'b1;
        @(negedge clk_i);
        take_i = 1'b0;
        chk("R10 refused entry", 32'(entry_o), 32'd0);
        chk("R10 intevt kept", 32'(intevt_o), 32'h5C0);
        exc_valid_i = 1'b1; exc_code_i = 12'h100;
        take_i = 1'b1;
        @(negedge clk_i);
        take_i = 1'b0;
        chk("R1 exc in slot with irq", 32'(expevt_o), 32'h100);
        chk("R6 slot rewind", spc_o, 32'h8C00_1FFE);
        @(negedge clk_i);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule